// File: doc/BRIEF.md
# Serial Flash Command Header Decoder

This block sits on the slave side of a serial flash interface and turns the first 32 bits of a selected frame into decoded fields. Chip select, serial clock and serial input come in asynchronously. They are brought into the system clock domain, and the serial input is sampled on each rising serial clock edge while chip select stays low. The first byte is the command opcode. The next three bytes are the address field, sent most significant bit first.

A page-size mode input picks one of two address layouts. In one layout a page holds 264 bytes and the byte offset takes 9 bits. In the other a page holds 256 bytes and the offset takes 8 bits. The block splits the address into page and offset. From the page it also derives the block index, which covers 8 pages, and a sector code used to target erases. The lowest sector is split into a small 8-page part and a 120-page remainder, and the sector code gives each part its own value. A one-cycle strobe marks a complete header. Downstream command logic reads the fields on that strobe.

Top module: `sfh_cmd_rx`

## Requirements
- R1: After reset, every field output is zero and `hdr_valid_o` is low.
- R2: A frame begins only when chip select falls. Serial clock edges seen while chip select is high shift nothing into the header.
- R3: Bits are taken most significant first on rising serial clock edges, and the first 8 bits of a frame form `opcode_o`.
- R4: With `page_mode`=0 (264-byte pages), `page_o` is address bits 19..9 and `offset_o` is address bits 8..0. Address bits 23..20 are ignored.
- R5: With `page_mode`=1 (256-byte pages), `page_o` is address bits 18..8 and `offset_o` is address bits 7..0 with bit 8 forced to zero. Address bits 23..19 are ignored.
- R6: `block_o` equals `page_o` divided by 8.
- R7: `sector_o` is 0 for pages 0 to 7, 1 for pages 8 to 127, and 2×(page/128) for pages 128 and above.
- R8: Each complete 32-bit header raises `hdr_valid_o` for exactly one system clock. All fields update in that same cycle and hold their values until the next complete header.
- R9: If chip select rises before the 32nd bit, the frame is aborted. No strobe is produced and the field outputs keep their previous values.
- R10: Serial clock edges after the 32nd bit of the same selection produce no further strobe and do not change the fields.
- R11: `page_mode` is captured when chip select falls. A change of `page_mode` later in the frame has no effect on that frame's decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, asynchronous |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_si | input | 1 | Serial data input, asynchronous |
| page_mode | input | 1 | 0 = 264-byte pages, 1 = 256-byte pages |
| opcode_o | output | 8 | Captured command opcode |
| page_o | output | 11 | Page number |
| offset_o | output | 9 | Byte offset within the page |
| block_o | output | 8 | Block index (page / 8) |
| sector_o | output | 5 | Sector code (see R7) |
| hdr_valid_o | output | 1 | One-cycle strobe on a complete header |

## Verification
A bit counter that slips by one shows up at the ports at once. On the very next frame the opcode and address come out shifted by one bit, or the strobe fires a serial bit early or late. A mode register that is reloaded mid-frame shows as a page and offset decoded with the wrong split on the frame where the mode input toggles. A frame state that fails to reset on an abort or after the 32nd bit shows as an extra strobe, or as changed fields, within one serial clock of the stray edge.

// File: rtl/sfh_pkg.sv
package sfh_pkg;

    localparam int OPC_W    = 8;
    localparam int ADR_W    = 24;
    localparam int PG_W     = 11;
    localparam int OFS_W    = 9;
    localparam int BLK_LOG  = 3;
    localparam int SEC_LOG  = 7;
    localparam int FRAME_W  = OPC_W + ADR_W;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int BLK_W    = PG_W - BLK_LOG;
    localparam int SEC_W    = PG_W - SEC_LOG + 1;

    typedef enum logic {
        PG_264 = 1'b0,
        PG_256 = 1'b1
    } pgmode_e;

    typedef enum logic {
        FR_IDLE  = 1'b0,
        FR_SHIFT = 1'b1
    } frame_e;

    typedef struct packed {
        logic [PG_W-1:0]  page;
        logic [OFS_W-1:0] ofs;
    } loc_t;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [PG_W-1:0]  page;
        logic [OFS_W-1:0] ofs;
        logic [BLK_W-1:0] blk;
        logic [SEC_W-1:0] sec;
    } hdr_t;

    // Page / offset split chosen by the page-size mode.
    function automatic loc_t split_addr(logic [ADR_W-1:0] a, pgmode_e m);
        loc_t r;
        if (m == PG_256) begin
            r.page = a[OFS_W-1 +: PG_W];
            r.ofs  = {1'b0, a[OFS_W-2:0]};
        end else begin
            r.page = a[OFS_W +: PG_W];
            r.ofs  = a[OFS_W-1:0];
        end
        return r;
    endfunction

    function automatic logic [BLK_W-1:0] block_of(logic [PG_W-1:0] pg);
        return pg[PG_W-1:BLK_LOG];
    endfunction

    // Lowest sector: small part gets code 0, remainder gets code 1;
    // higher sectors get twice their index.
    function automatic logic [SEC_W-1:0] sector_of(logic [PG_W-1:0] pg);
        logic [SEC_W-2:0] s;
        s = pg[PG_W-1:SEC_LOG];
        if (s == '0) begin
            return (pg[PG_W-1:BLK_LOG] != '0) ? SEC_W'(1) : '0;
        end
        return {s, 1'b0};
    endfunction

endpackage

// File: rtl/sfh_sync.sv
module sfh_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sfh_front.sv
module sfh_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sck_rise,
    output logic cs_fall,
    output logic cs_low,
    output logic si_s
);
    logic [2:0] raw, syn;
    logic       sck_s, csn_s;
    logic       sck_d, csn_d;

    assign raw = {cs_n, sck, si};

    sfh_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    assign csn_s = syn[2];
    assign sck_s = syn[1];
    assign si_s  = syn[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            csn_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            csn_d <= csn_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign cs_fall  = csn_d & ~csn_s;
    assign cs_low   = ~csn_s;
endmodule

// File: rtl/sfh_shift.sv
module sfh_shift
    import sfh_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sck_rise,
    input  logic               cs_fall,
    input  logic               cs_low,
    input  logic               si_s,
    input  pgmode_e            mode_in,
    output logic [FRAME_W-1:0] word,
    output pgmode_e            mode_q,
    output logic               done
);
    frame_e           state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FR_IDLE;
            cnt    <= '0;
            word   <= '0;
            mode_q <= PG_264;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cs_fall) begin
                state  <= FR_SHIFT;
                cnt    <= '0;
                mode_q <= mode_in;
            end else if (!cs_low) begin
                state <= FR_IDLE;
                cnt   <= '0;
            end else if (state == FR_SHIFT && sck_rise) begin
                word <= {word[FRAME_W-2:0], si_s};
                if (cnt == CNT_W'(FRAME_W - 1)) begin
                    done  <= 1'b1;
                    state <= FR_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_DONE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(sck_rise)); // R2
    AST_DONE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(cs_low)); // R9
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !cs_fall |=> $stable(mode_q)); // R11
endmodule

// File: rtl/sfh_decode.sv
module sfh_decode
    import sfh_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               done,
    input  logic [FRAME_W-1:0] word,
    input  pgmode_e            mode,
    output hdr_t               hdr,
    output logic               valid
);
    hdr_t nxt;
    loc_t loc;

    always_comb begin
        loc      = split_addr(word[ADR_W-1:0], mode);
        nxt.opc  = word[FRAME_W-1 -: OPC_W];
        nxt.page = loc.page;
        nxt.ofs  = loc.ofs;
        nxt.blk  = block_of(loc.page);
        nxt.sec  = sector_of(loc.page);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr   <= '0;
            valid <= 1'b0;
        end else begin
            valid <= done;
            if (done) hdr <= nxt;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid); // R8
    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(hdr)); // R8
    AST_BLOCK_OF_PAGE: assert property (@(posedge clk) disable iff (rst)
        valid |-> (hdr.blk == hdr.page[PG_W-1:BLK_LOG])); // R6
    AST_SECTOR_TOP: assert property (@(posedge clk) disable iff (rst)
        valid |-> (hdr.sec[SEC_W-1:1] == hdr.page[PG_W-1:SEC_LOG])); // R7
endmodule

// File: rtl/sfh_cmd_rx.sv
module sfh_cmd_rx
    import sfh_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_sck,
    input  logic             spi_cs_n,
    input  logic             spi_si,
    input  logic             page_mode,
    output logic [OPC_W-1:0] opcode_o,
    output logic [PG_W-1:0]  page_o,
    output logic [OFS_W-1:0] offset_o,
    output logic [BLK_W-1:0] block_o,
    output logic [SEC_W-1:0] sector_o,
    output logic             hdr_valid_o
);
    logic               sck_rise, cs_fall, cs_low, si_s, done;
    logic [FRAME_W-1:0] word;
    pgmode_e            mode_q;
    hdr_t               hdr;

    sfh_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst      (rst),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .si       (spi_si),
        .sck_rise (sck_rise),
        .cs_fall  (cs_fall),
        .cs_low   (cs_low),
        .si_s     (si_s)
    );

    sfh_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .sck_rise (sck_rise),
        .cs_fall  (cs_fall),
        .cs_low   (cs_low),
        .si_s     (si_s),
        .mode_in  (pgmode_e'(page_mode)),
        .word     (word),
        .mode_q   (mode_q),
        .done     (done)
    );

    sfh_decode u_decode (
        .clk   (clk),
        .rst   (rst),
        .done  (done),
        .word  (word),
        .mode  (mode_q),
        .hdr   (hdr),
        .valid (hdr_valid_o)
    );

    assign opcode_o = hdr.opc;
    assign page_o   = hdr.page;
    assign offset_o = hdr.ofs;
    assign block_o  = hdr.blk;
    assign sector_o = hdr.sec;
endmodule

// File: tb/tb_sfh_cmd_rx.sv
module tb_sfh_cmd_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_si = 1'b0;
    logic        page_mode = 1'b0;
    logic [7:0]  opcode_o;
    logic [10:0] page_o;
    logic [8:0]  offset_o;
    logic [7:0]  block_o;
    logic [4:0]  sector_o;
    logic        hdr_valid_o;

    int checks = 0;
    int errors = 0;
    int vcnt = 0;
    int run = 0;
    int maxrun = 0;

    always #5 clk = ~clk;

    sfh_cmd_rx dut (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .page_mode(page_mode), .opcode_o(opcode_o),
        .page_o(page_o), .offset_o(offset_o), .block_o(block_o),
        .sector_o(sector_o), .hdr_valid_o(hdr_valid_o)
    );

    always @(negedge clk) begin
        if (hdr_valid_o) begin
            vcnt++;
            run++;
            if (run > maxrun) maxrun = run;
        end else begin
            run = 0;
        end
    end

    // {mode, opcode, address}
    localparam logic [32:0] VEC [8] = '{
        {1'b0, 8'h82, 24'h000000},
        {1'b0, 8'h58, 24'hF00E05},
        {1'b1, 8'hD2, 24'h07FFFF},
        {1'b1, 8'h81, 24'hF80800},
        {1'b0, 8'h50, 24'h0FFFFF},
        {1'b1, 8'h7C, 24'h010000},
        {1'b0, 8'hA5, 24'h00FE00},
        {1'b1, 8'h3C, 24'h000780}
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wclk(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic frame(bit mode, bit [7:0] opc, bit [23:0] addr,
                         int nbits, bit flip);
        bit [31:0] w;
        w = {opc, addr};
        page_mode = mode;
        wclk(3);
        spi_cs_n = 1'b0;
        wclk(6);
        if (flip) page_mode = ~mode;
        for (int i = 0; i < nbits; i++) begin
            spi_si = (i < 32) ? w[31-i] : 1'b1;
            wclk(4);
            spi_sck = 1'b1;
            wclk(4);
            spi_sck = 1'b0;
        end
        wclk(8);
        spi_cs_n = 1'b1;
        wclk(8);
    endtask

    task automatic expect_hdr(bit mode, bit [7:0] opc, bit [23:0] addr);
        int pg, of, sc;
        if (mode) begin
            pg = (addr / 256) % 2048;
            of = addr % 256;
        end else begin
            pg = (addr / 512) % 2048;
            of = addr % 512;
        end
        if (pg < 8)        sc = 0;
        else if (pg < 128) sc = 1;
        else               sc = (pg / 128) * 2;
        check("R3 opcode", int'(opcode_o), int'(opc));
        check(mode ? "R5 page" : "R4 page", int'(page_o), pg);
        check(mode ? "R5 offset" : "R4 offset", int'(offset_o), of);
        check("R6 block", int'(block_o), pg / 8);
        check("R7 sector", int'(sector_o), sc);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v0;
        bit [7:0] po, pp, pof;
        wclk(4);
        rst = 1'b0;
        wclk(2);
        @(negedge clk);
        // R1 reset state
        check("R1 opcode", int'(opcode_o), 0);
        check("R1 page", int'(page_o), 0);
        check("R1 offset", int'(offset_o), 0);
        check("R1 sector", int'(sector_o), 0);
        check("R1 valid", int'(hdr_valid_o), 0);

        foreach (VEC[k]) begin
            v0 = vcnt;
            frame(VEC[k][32], VEC[k][31:24], VEC[k][23:0], 32, 1'b0);
            @(negedge clk);
            check("R8 one strobe", vcnt - v0, 1);
            expect_hdr(VEC[k][32], VEC[k][31:24], VEC[k][23:0]);
        end
        check("R8 strobe width", maxrun, 1);

        // R2: serial clock toggles with chip select high shift nothing
        for (int i = 0; i < 5; i++) begin
            spi_si = 1'b1;
            wclk(4); spi_sck = 1'b1; wclk(4); spi_sck = 1'b0;
        end
        v0 = vcnt;
        frame(1'b0, 8'h1B, 24'h023456, 32, 1'b0);
        @(negedge clk);
        check("R2 strobe", vcnt - v0, 1);
        expect_hdr(1'b0, 8'h1B, 24'h023456);

        // R9: abort after 20 bits
        po = opcode_o; pp = page_o[7:0]; pof = offset_o[7:0];
        v0 = vcnt;
        frame(1'b1, 8'hEE, 24'h7FFFFF, 20, 1'b0);
        @(negedge clk);
        check("R9 no strobe", vcnt - v0, 0);
        check("R9 opcode held", int'(opcode_o), int'(po));
        check("R9 page held", int'(page_o[7:0]), int'(pp));
        check("R9 offset held", int'(offset_o[7:0]), int'(pof));
        v0 = vcnt;
        frame(1'b1, 8'h66, 24'h012345, 32, 1'b0);
        @(negedge clk);
        check("R9 recovery strobe", vcnt - v0, 1);
        expect_hdr(1'b1, 8'h66, 24'h012345);

        // R10: extra bits after the header
        v0 = vcnt;
        frame(1'b0, 8'h0B, 24'h0A5A5A, 44, 1'b0);
        @(negedge clk);
        check("R10 single strobe", vcnt - v0, 1);
        expect_hdr(1'b0, 8'h0B, 24'h0A5A5A);

        // R11: mode toggled mid-frame is ignored
        v0 = vcnt;
        frame(1'b0, 8'hC3, 24'h0C1F37, 32, 1'b1);
        @(negedge clk);
        check("R11 strobe", vcnt - v0, 1);
        expect_hdr(1'b0, 8'hC3, 24'h0C1F37);
        v0 = vcnt;
        frame(1'b1, 8'h3A, 24'h0C1F37, 32, 1'b1);
        @(negedge clk);
        check("R11 strobe b", vcnt - v0, 1);
        expect_hdr(1'b1, 8'h3A, 24'h0C1F37);
        check("R8 strobe width final", maxrun, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule